// File: doc/BRIEF.md
# Edge Hit Time Digitizer

This block time-stamps the transitions of a single hit input. A free-running coarse counter is joined with a fine interpolation code, supplied from outside by a delay-line interpolator, to form a time value. Whenever a selected transition of the hit signal is seen, that time value is captured and handed out as a hit word. Each word carries a flag that tells a rising (leading) edge apart from a falling (trailing) one.

Four capture modes are available: rising edges only, falling edges only, both edges as independent measurements, or a pair mode. Pair mode returns one word per pulse, holding the rising-edge time and the pulse width. A resolution selector sets the width of the time field. The time value wraps at that width. A bunch-count reset input clears the coarse counter so that several channels can be aligned to a common origin.

The hit input is asynchronous. It passes through a two-flop synchronizer, and the fine code is delayed by the same number of stages so that the two stay aligned. At most one word leaves the block per clock cycle, marked by a valid strobe.

Top module: `hit_edge_digitizer`

## Requirements
- R1: While `rst_ni` is low, and for the two clock edges after it rises, `word_valid_o` and `pair_err_o` are 0. The first functional update takes place on the third rising clock edge with `rst_ni` high.
- R2: With `mode_i` = 0 (rising only), each rising edge of `hit_i` gives one word with `word_trail_o` = 0. Falling edges give no word.
- R3: With `mode_i` = 1 (falling only), each falling edge gives one word with `word_trail_o` = 1. Rising edges give no word.
- R4: With `mode_i` = 2 (both), every edge gives one word, with `word_trail_o` = 1 for a falling edge and 0 for a rising edge.
- R5: Suppose a new level of `hit_i` is first sampled at clock edge k. Its word is presented after edge k+2. The word's time is {coarse count after edge k+1, `fine_i` sampled at edge k}, with the fine code in the low 5 bits.
- R6: With `res_i` at 0 or 1, the time field is 19 bits and the coarse counter wraps from 2^14-1 to 0. With `res_i` at 2 or 3, the time field is 17 bits, bits 18:17 of `word_time_o` are 0, and the counter wraps from 2^12-1 to 0.
- R7: When `bc_rst_i` is high at a clock edge, the coarse count after that edge is 0. This takes priority over the increment.
- R8: With `mode_i` = 3 (pair), a rising edge arms the channel and gives no word. The following falling edge gives one word with `word_trail_o` = 0. That word's time is the rising-edge time, and its width is (falling time − rising time) modulo 2^N, where N is the time field width.
- R9: The pair width saturates at 1023 (all ones in the 10-bit width field) when the true difference is larger.
- R10: In pair mode, a falling edge with no armed rising edge gives no word. Instead, `pair_err_o` pulses high for exactly the cycle in which the word would have appeared.
- R11: Words from modes 0, 1 and 2 carry a width field of 0.
- R12: At most one word is presented per cycle. A hit toggling on every clock gives a valid word on every consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | 1 | Asynchronous hit signal |
| fine_i | input | 5 | Fine interpolation code, time-aligned with `hit_i` |
| bc_rst_i | input | 1 | Synchronous bunch-count reset of the coarse counter |
| mode_i | input | 2 | 0 rising, 1 falling, 2 both, 3 pair |
| res_i | input | 2 | 0/1 give a 19-bit time field, 2/3 give a 17-bit time field |
| word_valid_o | output | 1 | Hit word valid strobe |
| word_trail_o | output | 1 | 1 when the word records a falling edge |
| word_time_o | output | 19 | Captured time {coarse, fine} |
| word_width_o | output | 10 | Pulse width in pair mode, otherwise 0 |
| pair_err_o | output | 1 | Pulse for an unpaired falling edge in pair mode |

## Verification
Two functions can land in the same cycle, and each collision is forced deliberately. The first is a bunch-count reset meeting an edge capture: `hit_i` rises one cycle before `bc_rst_i` is pulsed, so the captured coarse field must read zero and the low bits must hold only the fine code. The second is a counter wrap meeting a capture: after a bunch-count reset the bench waits exactly one wrap period in each resolution before raising the hit, and expects coarse zero again with the upper bits cleared in the narrow setting. Around these directed cases, seeded random toggling across all modes, resolutions and occasional bunch-count resets is compared cycle by cycle against a reference computed in the bench from the requirements.

// File: rtl/hed_pkg.sv
package hed_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_PAIR = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    RES_STEP_FINE     = 2'd0,
    RES_STEP_MID      = 2'd1,
    RES_STEP_WIDE     = 2'd2,
    RES_STEP_WIDE_ALT = 2'd3
  } res_sel_e;

endpackage

// File: rtl/hed_rst_sync.sv
module hed_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;

endmodule

// File: rtl/hed_sync_edge.sv
module hed_sync_edge #(
  parameter int FINE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic              rise_o,
  output logic              fall_o,
  output logic [FINE_W-1:0] fine_o
);

  logic              meta_q, sync_q, prev_q;
  logic [FINE_W-1:0] fine1_q, fine2_q;

  // two synchronizer flops plus one history flop; fine code delayed alongside
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      prev_q  <= 1'b0;
      fine1_q <= '0;
      fine2_q <= '0;
    end else begin
      meta_q  <= hit_i;
      sync_q  <= meta_q;
      prev_q  <= sync_q;
      fine1_q <= fine_i;
      fine2_q <= fine1_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
  assign fine_o = fine2_q;

  // R5: the fine code seen at detection is the one sampled two edges earlier
  p_fine_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> (fine_o == $past(fine_i, 2)));

endmodule

// File: rtl/hed_coarse_cnt.sv
module hed_coarse_cnt #(
  parameter int CNT_W        = 14,
  parameter int CNT_W_NARROW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bc_rst_i,
  input  logic             narrow_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] NARROW_MASK =
    {{(CNT_W-CNT_W_NARROW){1'b0}}, {CNT_W_NARROW{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (narrow_i) cnt_d = cnt_d & NARROW_MASK;
    if (bc_rst_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_bc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_rst_i |=> (cnt_o == '0));

  p_wrap_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bc_rst_i && narrow_i && cnt_o == NARROW_MASK) |=> (cnt_o == '0));

  p_wrap_wide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bc_rst_i && !narrow_i && (&cnt_o)) |=> (cnt_o == '0));

endmodule

// File: rtl/hed_pair_track.sv
module hed_pair_track #(
  parameter int TIME_W  = 19,
  parameter int WIDTH_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pair_en_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [TIME_W-1:0]  time_i,
  input  logic [TIME_W-1:0]  tmask_i,
  output logic               fire_o,
  output logic               err_o,
  output logic [TIME_W-1:0]  lead_o,
  output logic [WIDTH_W-1:0] width_o
);

  logic              armed_q, armed_d;
  logic [TIME_W-1:0] lead_q, lead_d;
  logic              lead_en;
  logic [TIME_W-1:0] diff;

  always_comb begin
    armed_d = armed_q;
    lead_en = 1'b0;
    lead_d  = time_i;
    if (!pair_en_i) begin
      armed_d = 1'b0;
    end else if (rise_i) begin
      armed_d = 1'b1;
      lead_en = 1'b1;
    end else if (fall_i) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      lead_q  <= '0;
    end else begin
      armed_q <= armed_d;
      if (lead_en) lead_q <= lead_d;
    end
  end

  assign fire_o = pair_en_i & fall_i & armed_q;
  assign err_o  = pair_en_i & fall_i & ~armed_q;
  assign lead_o = lead_q;
  assign diff   = (time_i - lead_q) & tmask_i;

  generate
    if (WIDTH_W < TIME_W) begin : g_sat
      always_comb begin
        if (|diff[TIME_W-1:WIDTH_W]) width_o = '1;
        else                         width_o = diff[WIDTH_W-1:0];
      end
    end else begin : g_wide
      assign width_o = WIDTH_W'(diff);
    end
  endgenerate

  p_arm_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_en_i && rise_i) |=> armed_q);

  p_disarm_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !rise_i) |=> !armed_q);

endmodule

// File: rtl/hit_edge_digitizer.sv
module hit_edge_digitizer
  import hed_pkg::*;
#(
  parameter int FINE_W        = 5,
  parameter int TIME_W        = 19,
  parameter int TIME_W_NARROW = 17,
  parameter int WIDTH_W       = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [FINE_W-1:0]  fine_i,
  input  logic               bc_rst_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         res_i,
  output logic               word_valid_o,
  output logic               word_trail_o,
  output logic [TIME_W-1:0]  word_time_o,
  output logic [WIDTH_W-1:0] word_width_o,
  output logic               pair_err_o
);

  localparam int CNT_W        = TIME_W - FINE_W;
  localparam int CNT_W_NARROW = TIME_W_NARROW - FINE_W;
  localparam logic [TIME_W-1:0] TMASK_NARROW =
    {{(TIME_W-TIME_W_NARROW){1'b0}}, {TIME_W_NARROW{1'b1}}};

  edge_sel_e mode_e;
  res_sel_e  res_e;
  logic      narrow;
  logic      rst_n_int;

  logic              rise, fall;
  logic [FINE_W-1:0] fine_al;
  logic [CNT_W-1:0]  coarse;
  logic [TIME_W-1:0] tmask, time_now;

  logic               fire, perr;
  logic [TIME_W-1:0]  lead_time;
  logic [WIDTH_W-1:0] pair_width;

  logic               valid_d, trail_d, err_d;
  logic [TIME_W-1:0]  time_d;
  logic [WIDTH_W-1:0] width_d;

  logic               valid_q, trail_q, err_q;
  logic [TIME_W-1:0]  time_q;
  logic [WIDTH_W-1:0] width_q;

  assign mode_e = edge_sel_e'(mode_i);
  assign res_e  = res_sel_e'(res_i);
  assign narrow = (res_e == RES_STEP_WIDE) || (res_e == RES_STEP_WIDE_ALT);
  assign tmask  = narrow ? TMASK_NARROW : '1;

  hed_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  hed_sync_edge #(.FINE_W(FINE_W)) u_sync_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .hit_i  (hit_i),
    .fine_i (fine_i),
    .rise_o (rise),
    .fall_o (fall),
    .fine_o (fine_al)
  );

  hed_coarse_cnt #(.CNT_W(CNT_W), .CNT_W_NARROW(CNT_W_NARROW)) u_coarse_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .bc_rst_i (bc_rst_i),
    .narrow_i (narrow),
    .cnt_o    (coarse)
  );

  assign time_now = {coarse, fine_al} & tmask;

  hed_pair_track #(.TIME_W(TIME_W), .WIDTH_W(WIDTH_W)) u_pair_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .pair_en_i (mode_e == EDGE_PAIR),
    .rise_i    (rise),
    .fall_i    (fall),
    .time_i    (time_now),
    .tmask_i   (tmask),
    .fire_o    (fire),
    .err_o     (perr),
    .lead_o    (lead_time),
    .width_o   (pair_width)
  );

  // next-state selection of the output word
  always_comb begin
    valid_d = 1'b0;
    trail_d = 1'b0;
    err_d   = 1'b0;
    time_d  = time_now;
    width_d = '0;
    unique case (mode_e)
      EDGE_RISE: valid_d = rise;
      EDGE_FALL: begin
        valid_d = fall;
        trail_d = 1'b1;
      end
      EDGE_ANY: begin
        valid_d = rise | fall;
        trail_d = fall;
      end
      EDGE_PAIR: begin
        valid_d = fire;
        time_d  = lead_time;
        width_d = pair_width;
        err_d   = perr;
      end
      default: ;
    endcase
  end

  // output register; the word fields load only when a word is produced
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      trail_q <= 1'b0;
      time_q  <= '0;
      width_q <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (valid_d) begin
        trail_q <= trail_d;
        time_q  <= time_d;
        width_q <= width_d;
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_trail_o = trail_q;
  assign word_time_o  = time_q;
  assign word_width_o = width_q;
  assign pair_err_o   = err_q;

  p_lead_only_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (word_valid_o && $past(mode_e) == EDGE_RISE) |-> !word_trail_o);

  p_trail_only_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (word_valid_o && $past(mode_e) == EDGE_FALL) |-> word_trail_o);

  p_pair_tag_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (word_valid_o && $past(mode_e) == EDGE_PAIR) |-> !word_trail_o);

  p_narrow_time_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (word_valid_o && $past(narrow) && $past(mode_e) != EDGE_PAIR)
      |-> (word_time_o[TIME_W-1:TIME_W_NARROW] == '0));

  p_err_no_word_r10: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    pair_err_o |-> !word_valid_o);

  p_width_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (word_valid_o && $past(mode_e) != EDGE_PAIR) |-> (word_width_o == '0));

endmodule

// File: tb/hit_edge_digitizer_tb_top.sv
module hit_edge_digitizer_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        hit;
  logic [4:0]  fine;
  logic        bc_rst;
  logic [1:0]  mode;
  logic [1:0]  res;
  logic        word_valid, word_trail, pair_err;
  logic [18:0] word_time;
  logic [9:0]  word_width;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit checking_on = 1'b0;

  always #2 clk = ~clk;

  hit_edge_digitizer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .fine_i       (fine),
    .bc_rst_i     (bc_rst),
    .mode_i       (mode),
    .res_i        (res),
    .word_valid_o (word_valid),
    .word_trail_o (word_trail),
    .word_time_o  (word_time),
    .word_width_o (word_width),
    .pair_err_o   (pair_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference computed from the requirements, updated at every clock edge
  int          since = 0;
  logic        h1, h2, h3;
  logic [4:0]  f1, f2;
  logic [13:0] c1;
  logic        armed;
  logic [18:0] lead;
  logic        ev, et, ee;
  logic [18:0] etime;
  logic [9:0]  ew;
  logic [1:0]  em;

  always @(posedge clk) begin : ref_model
    logic        rise_m, fall_m;
    logic [18:0] tmk, tnow, d;
    logic [13:0] cmk;
    if (!rst_ni) since = 0;
    else if (since < 3) since = since + 1;
    if (since <= 2) begin
      h1 = 0; h2 = 0; h3 = 0; f1 = 0; f2 = 0; c1 = 0;
      armed = 0; lead = 0;
      ev = 0; et = 0; ee = 0; etime = 0; ew = 0; em = mode;
    end else begin
      tmk    = res[1] ? 19'h1FFFF : 19'h7FFFF;
      cmk    = res[1] ? 14'h0FFF  : 14'h3FFF;
      rise_m = h2 & ~h3;
      fall_m = ~h2 & h3;
      tnow   = {c1, f2} & tmk;
      ev = 0; et = 0; ee = 0; etime = tnow; ew = 0; em = mode;
      case (mode)
        2'd0: ev = rise_m;
        2'd1: begin ev = fall_m; et = 1; end
        2'd2: begin ev = rise_m | fall_m; et = fall_m; end
        default: begin
          if (fall_m) begin
            if (armed) begin
              ev = 1; etime = lead;
              d = (tnow - lead) & tmk;
              ew = (d > 19'd1023) ? 10'd1023 : d[9:0];
            end else ee = 1;
          end
        end
      endcase
      if (mode != 2'd3) armed = 0;
      else if (rise_m) begin armed = 1; lead = tnow; end
      else if (fall_m) armed = 0;
      h3 = h2; h2 = h1; h1 = hit;
      f2 = f1; f1 = fine;
      c1 = bc_rst ? 14'd0 : ((c1 + 14'd1) & cmk);
    end
  end

  always @(negedge clk) begin : ref_compare
    string tg;
    if (checking_on) begin
      tg = (em == 2'd0) ? "R2" : (em == 2'd1) ? "R3" : (em == 2'd2) ? "R4" : "R8";
      chk(word_valid == ev, tg, "valid strobe vs reference", word_valid, ev);
      chk(pair_err == ee, "R10", "pair error strobe vs reference", pair_err, ee);
      if (ev) begin
        chk(word_trail == et, tg, "edge flag", word_trail, et);
        chk(word_time == etime, "R5", "time field", word_time, etime);
        chk(word_width == ew, (em == 2'd3) ? "R9" : "R11", "width field", word_width, ew);
      end
    end
  end

  task automatic idle(input int n);
    hit = 0; bc_rst = 0;
    repeat (n) @(negedge clk);
  endtask

  // wrap a capture exactly on the counter roll-over after a bunch-count reset
  task automatic wrap_test(input logic [1:0] r, input int period);
    mode = 2'd0; res = r;
    idle(6);
    bc_rst = 1;
    @(negedge clk);
    bc_rst = 0;
    repeat (period - 2) @(negedge clk);
    fine = 5'h0A; hit = 1;
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b1, "R6", "wrap capture valid", word_valid, 1);
    chk(word_time == 19'h0000A, "R6", "coarse zero after wrap", word_time, 19'h0000A);
    idle(6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R12 watchdog expired: actual 200000 cycles expected fewer");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd7321));
    rst_ni = 0; hit = 0; fine = 0; bc_rst = 0; mode = 0; res = 0;
    repeat (5) @(negedge clk);
    chk(word_valid == 1'b0, "R1", "valid in reset", word_valid, 0);
    chk(pair_err == 1'b0, "R1", "error in reset", pair_err, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(word_valid == 1'b0, "R1", "valid during release", word_valid, 0);
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0, "R1", "valid after release", word_valid, 0);
    checking_on = 1;

    // R7 with R5: bunch-count reset in the same cycle as the capture
    mode = 2'd0; res = 2'd0;
    idle(6);
    fine = 5'h13; hit = 1;
    @(negedge clk); bc_rst = 1;
    @(negedge clk); bc_rst = 0;
    @(negedge clk);
    chk(word_valid == 1'b1, "R7", "capture valid", word_valid, 1);
    chk(word_time[18:5] == 14'd0, "R7", "coarse after bunch reset", word_time[18:5], 0);
    chk(word_time[4:0] == 5'h13, "R5", "fine code in low bits", word_time[4:0], 5'h13);
    idle(6);

    // R6: wrap in both resolutions
    wrap_test(2'd2, 4096);
    wrap_test(2'd0, 16384);

    // R9: long pulse saturates the width
    mode = 2'd3; res = 2'd0;
    idle(6);
    hit = 1;
    repeat (60) @(negedge clk);
    hit = 0;
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b1, "R8", "pair word valid", word_valid, 1);
    chk(word_trail == 1'b0, "R8", "pair word flag", word_trail, 0);
    chk(word_width == 10'h3FF, "R9", "saturated width", word_width, 10'h3FF);
    idle(6);

    // R10: falling edge without an armed rising edge
    mode = 2'd0;
    idle(5);
    hit = 1;
    repeat (5) @(negedge clk);
    mode = 2'd3;
    repeat (2) @(negedge clk);
    hit = 0;
    repeat (3) @(negedge clk);
    chk(pair_err == 1'b1, "R10", "unpaired error pulse", pair_err, 1);
    chk(word_valid == 1'b0, "R10", "no word for unpaired edge", word_valid, 0);
    @(negedge clk);
    chk(pair_err == 1'b0, "R10", "error pulse one cycle", pair_err, 0);
    idle(6);

    // R12 and R11: toggle every cycle in both-edge mode
    mode = 2'd2; res = 2'd1;
    idle(6);
    for (int idx = 0; idx < 23; idx++) begin
      if (idx >= 3) begin
        chk(word_valid == 1'b1, "R12", "back-to-back word", word_valid, 1);
        chk(word_trail == ((idx - 3) % 2 == 1), "R4", "alternating flag", word_trail,
            ((idx - 3) % 2 == 1));
        chk(word_width == 10'd0, "R11", "width zero outside pair", word_width, 0);
      end
      if (idx < 20) hit = ~hit;
      @(negedge clk);
    end
    idle(6);

    // seeded random across modes and resolutions
    for (int ph = 0; ph < 8; ph++) begin
      mode = ph[1:0];
      res  = 2'($urandom % 4);
      for (int cy = 0; cy < 3000; cy++) begin
        if ($urandom % 4 == 0) hit = ~hit;
        fine   = 5'($urandom);
        bc_rst = ($urandom % 200 == 0);
        @(negedge clk);
      end
      idle(6);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule